// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a compact processor built around one 16-bit accumulator. It talks to a word-addressed memory through a single port with address, write data, read data, a write strobe and a read strobe. Every instruction is one memory word. The upper four bits select the operation and the lower twelve bits give a direct operand address. Eight operations are defined: load, store, add, subtract, an unconditional jump, a jump on a non-negative (or, by parameter, strictly positive) accumulator, a jump on a nonzero accumulator, and stop.

Each instruction runs as a short sequence of cycles. A fetch cycle reads the word at the program counter. A decode cycle latches it and advances the counter. An execute cycle performs the access or the jump. Operations that read an operand take one more cycle to take in the returned data. Once stop executes, the core raises its halted output and never touches memory again until it is reset. The eight unassigned opcodes are harmless: they only advance the program counter.

Top module: `acc_cpu`

## Requirements
- R1: After a synchronous active-high reset is released, the accumulator, program counter and halted output are zero, and the first cycle issues a read at address 0.
- R2: Every instruction is fetched with a read at the program counter. The counter then moves to the next word and wraps from 4095 to 0.
- R3: Opcode 0 loads the accumulator from the word at the operand address. Opcode 2 adds that word to it and opcode 3 subtracts it. Both wrap modulo 2^16 and keep no flags. Nothing else changes the accumulator.
- R4: Opcode 1 writes the accumulator to the operand address with one write-strobe cycle. Read and write strobes are never active together.
- R5: Opcode 4 sets the program counter to the operand, so the next fetch reads from there.
- R6: Opcode 5 jumps when bit 15 of the accumulator is clear. With the strict parameter set, the accumulator must also be nonzero.
- R7: Opcode 6 jumps when the accumulator is nonzero; otherwise execution falls through.
- R8: Opcode 7 raises halted in the cycle after its execute cycle, whatever its operand bits hold. From then on halted stays high and no read or write is issued.
- R9: Opcodes 8 to 15 issue no memory access and change neither the accumulator nor memory. Only the program counter moves on.
- R10: The opcode is taken from bits 15:12 of the instruction word and the operand address from bits 11:0.
- R11: Read data are used in the cycle after the read strobe. Load, add and subtract take four cycles. Store, jumps and undefined opcodes take three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address for the current access |
| mem_re | output | 1 | Read strobe; data return on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (the accumulator) |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | High once stop has executed |

## Verification
The bench builds two copies of the core. One uses the default non-negative test on opcode 5 and is compared cycle by cycle against a behavioural model. The other is built with the strict test, and its stored results show that a zero accumulator takes the branch under one setting and falls through under the other. One self-modifying program drives both copies. It jumps to the last word, so the counter wraps, and then overwrites address 0 with a stop word that has nonzero operand bits. A single run therefore covers wrap-around arithmetic, counter wrap, undefined opcodes and halting.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd0;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'd1;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'd2;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'd3;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 4'd4;
  localparam logic [OPC_W-1:0] OPC_JPOS  = 4'd5;
  localparam logic [OPC_W-1:0] OPC_JNZ   = 4'd6;
  localparam logic [OPC_W-1:0] OPC_STOP  = 4'd7;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_READ   = 3'd3,
    ST_HALT   = 3'd4
  } cpu_state_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    rd;
    logic    wr;
    alu_op_e alu;
    logic    jump;
    logic    stop;
  } exec_ctl_t;
endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
#(
  parameter bit POS_STRICT = 1'b0
) (
  input  logic [OPC_W-1:0] opc,
  input  logic             acc_neg,
  input  logic             acc_zero,
  output exec_ctl_t        ctl
);
  logic pos_ok;

  generate
    if (POS_STRICT) begin : g_strict
      assign pos_ok = !acc_neg && !acc_zero;
    end else begin : g_nonneg
      assign pos_ok = !acc_neg;
    end
  endgenerate

  always_comb begin
    ctl = '0;
    case (opc)
      OPC_LOAD:  begin ctl.rd = 1'b1; ctl.alu = ALU_PASS; end
      OPC_STORE: ctl.wr = 1'b1;
      OPC_ADD:   begin ctl.rd = 1'b1; ctl.alu = ALU_ADD; end
      OPC_SUB:   begin ctl.rd = 1'b1; ctl.alu = ALU_SUB; end
      OPC_JUMP:  ctl.jump = 1'b1;
      OPC_JPOS:  ctl.jump = pos_ok;
      OPC_JNZ:   ctl.jump = !acc_zero;
      OPC_STOP:  ctl.stop = 1'b1;
      default:   ctl = '0;  // reserved opcodes: no-op
    endcase
  end
endmodule

// File: rtl/acc_cpu_fsm.sv
module acc_cpu_fsm
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  exec_ctl_t  ctl,
  output cpu_state_e state
);
  cpu_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = ST_EXEC;
      ST_EXEC: begin
        if (ctl.stop)    nxt = ST_HALT;
        else if (ctl.rd) nxt = ST_READ;
        else             nxt = ST_FETCH;
      end
      ST_READ:   nxt = ST_FETCH;
      ST_HALT:   nxt = ST_HALT;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter  int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ir_load,
  input  logic              pc_step,
  input  logic              pc_jump,
  input  logic              acc_load,
  input  alu_op_e           alu,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] acc_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] ir_q
);
  function automatic logic [DATA_W-1:0] wrap_add(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] wrap_sub(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic [DATA_W-1:0] alu_result(alu_op_e op, logic [DATA_W-1:0] a,
                                                   logic [DATA_W-1:0] b);
    case (op)
      ALU_ADD: return wrap_add(a, b);
      ALU_SUB: return wrap_sub(a, b);
      default: return b;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      pc_q  <= '0;
      ir_q  <= '0;
    end else begin
      if (ir_load) ir_q <= rdata;
      if (pc_step)      pc_q <= pc_q + 1'b1;
      else if (pc_jump) pc_q <= ir_q[ADDR_W-1:0];
      if (acc_load) acc_q <= alu_result(alu, acc_q, rdata);
    end
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter  int ADDR_W     = 12,
  parameter  bit POS_STRICT = 1'b0,
  localparam int DATA_W     = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);
  cpu_state_e        state;
  exec_ctl_t         ctl;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] ir_q;
  logic [ADDR_W-1:0] pc_q;

  // named internal events
  logic pc_step_ev;
  logic exec_ev;
  logic jump_ev;
  logic stop_ev;
  logic acc_wr_ev;

  assign pc_step_ev = (state == ST_DECODE);
  assign exec_ev    = (state == ST_EXEC);
  assign jump_ev    = exec_ev && ctl.jump;
  assign stop_ev    = exec_ev && ctl.stop;
  assign acc_wr_ev  = (state == ST_READ);

  acc_cpu_decode #(.POS_STRICT(POS_STRICT)) dec_i (
    .opc      (ir_q[DATA_W-1 -: OPC_W]),
    .acc_neg  (acc_q[DATA_W-1]),
    .acc_zero (acc_q == '0),
    .ctl      (ctl)
  );

  acc_cpu_fsm fsm_i (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .state (state)
  );

  acc_cpu_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .ir_load  (pc_step_ev),
    .pc_step  (pc_step_ev),
    .pc_jump  (jump_ev),
    .acc_load (acc_wr_ev),
    .alu      (ctl.alu),
    .rdata    (mem_rdata),
    .acc_q    (acc_q),
    .pc_q     (pc_q),
    .ir_q     (ir_q)
  );

  assign mem_addr  = (state == ST_FETCH) ? pc_q : ir_q[ADDR_W-1:0];
  assign mem_re    = (state == ST_FETCH) || (exec_ev && ctl.rd);
  assign mem_we    = exec_ev && ctl.wr;
  assign mem_wdata = acc_q;
  assign halted    = (state == ST_HALT);
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_re,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              halted,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] ir_q,
  input logic [DATA_W-1:0] acc_q,
  input logic              pc_step_ev,
  input logic              jump_ev,
  input logic              stop_ev,
  input logic              acc_wr_ev
);
  p_start_at_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_re && mem_addr == '0 && !halted));

  p_pc_advance_r2: assert property (@(posedge clk) disable iff (rst)
    pc_step_ev |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

  p_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !acc_wr_ev |=> (acc_q == $past(acc_q)));

  p_no_rw_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  p_jump_target_r5: assert property (@(posedge clk) disable iff (rst)
    jump_ev |=> (pc_q == $past(ir_q[ADDR_W-1:0])));

  p_stop_halts_r8: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> halted);

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_re && !mem_we));
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .mem_re     (mem_re),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .halted     (halted),
  .pc_q       (pc_q),
  .ir_q       (ir_q),
  .acc_q      (acc_q),
  .pc_step_ev (pc_step_ev),
  .jump_ev    (jump_ev),
  .stop_ev    (stop_ev),
  .acc_wr_ev  (acc_wr_ev)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  int n_checks = 0;
  int n_fail   = 0;

  // default build (non-negative test on opcode 5)
  logic [11:0] addr0;  logic re0, we0, halt0;
  logic [15:0] wd0, rd0;
  logic [15:0] mem0 [4096];

  // strict build (strictly positive test on opcode 5)
  logic [11:0] addr1;  logic re1, we1, halt1;
  logic [15:0] wd1, rd1;
  logic [15:0] mem1 [4096];

  acc_cpu #(.ADDR_W(12), .POS_STRICT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .mem_addr(addr0), .mem_re(re0), .mem_we(we0),
    .mem_wdata(wd0), .mem_rdata(rd0), .halted(halt0));

  acc_cpu #(.ADDR_W(12), .POS_STRICT(1'b1)) dut_gt_i (
    .clk(clk), .rst(rst), .mem_addr(addr1), .mem_re(re1), .mem_we(we1),
    .mem_wdata(wd1), .mem_rdata(rd1), .halted(halt1));

  // memories: one-cycle read latency
  always @(posedge clk) begin
    if (re0) rd0 <= mem0[addr0];
    if (we0) mem0[addr0] = wd0;
  end
  always @(posedge clk) begin
    if (re1) rd1 <= mem1[addr1];
    if (we1) mem1[addr1] = wd1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model for dut_i
  logic [15:0] model_mem [4096];
  int          m_phase;   // 0 fetch, 1 decode, 2 exec, 3 read, 4 halted
  logic [15:0] m_acc, m_ir;
  logic [11:0] m_pc;
  string       m_tag = "R1";
  bit          running = 1'b0;

  task automatic poke(input int a, input logic [15:0] v);
    mem0[a] = v; mem1[a] = v; model_mem[a] = v;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_acc = '0; m_pc = '0; m_ir = '0; m_tag = "R1";
    end else begin
      case (m_phase)
        0: m_phase = 1;
        1: begin m_ir = model_mem[m_pc]; m_pc = m_pc + 12'd1; m_phase = 2; end
        2: begin
          m_phase = 0;
          m_tag = "R2";
          case (int'(m_ir[15:12]))  // R10: opcode in 15:12, operand in 11:0
            0, 2, 3: m_phase = 3;
            1: model_mem[m_ir[11:0]] = m_acc;
            4: begin m_pc = m_ir[11:0]; m_tag = "R5"; end
            5: begin if (!m_acc[15]) m_pc = m_ir[11:0]; m_tag = "R6"; end
            6: begin if (m_acc != 0) m_pc = m_ir[11:0]; m_tag = "R7"; end
            7: m_phase = 4;
            default: m_tag = "R9";
          endcase
        end
        3: begin
          case (int'(m_ir[15:12]))
            0: m_acc = model_mem[m_ir[11:0]];
            2: m_acc = m_acc + model_mem[m_ir[11:0]];
            default: m_acc = m_acc - model_mem[m_ir[11:0]];
          endcase
          m_phase = 0;
        end
        default: m_phase = 4;
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (running && !rst) begin
      bit    e_re, e_we;
      logic [11:0] e_addr;
      string t;
      int    op;
      e_re = 0; e_we = 0; e_addr = '0; t = "R11";
      op = int'(m_ir[15:12]);
      case (m_phase)
        0: begin e_re = 1; e_addr = m_pc; t = m_tag; end
        2: begin
          if (op == 0 || op == 2 || op == 3) begin e_re = 1; e_addr = m_ir[11:0]; t = "R3"; end
          else if (op == 1) begin e_we = 1; e_addr = m_ir[11:0]; t = "R4"; end
          else if (op >= 8) t = "R9";
        end
        4: t = "R8";
        default: t = "R11";
      endcase
      check(halt0 == (m_phase == 4), t, int'(halt0), int'(m_phase == 4));
      check(re0 == e_re, t, int'(re0), int'(e_re));
      check(we0 == e_we, t, int'(we0), int'(e_we));
      if (e_re || e_we) check(addr0 == e_addr, t, int'(addr0), int'(e_addr));
      if (e_we) check(wd0 == m_acc, "R4", int'(wd0), int'(m_acc));
    end
  end

  initial begin
    bit done;
    for (int i = 0; i < 4096; i++) poke(i, 16'h0000);
    poke(12'h000, 16'h4010);  // JMP 010
    poke(12'h010, 16'h0100);  // LDA 100 (=5)
    poke(12'h011, 16'h2101);  // ADD 101 (=FFFF) -> 4
    poke(12'h012, 16'h3102);  // SUB 102 (=7)    -> FFFD
    poke(12'h013, 16'h1200);  // STO 200
    poke(12'h014, 16'h5018);  // JPOS, negative: not taken
    poke(12'h015, 16'h6017);  // JNZ taken
    poke(12'h016, 16'h7000);  // STOP (skipped)
    poke(12'h017, 16'h0103);  // LDA 103 (=0)
    poke(12'h018, 16'h6016);  // JNZ on zero: not taken
    poke(12'h019, 16'h501C);  // JPOS on zero: taken only when non-strict
    poke(12'h01A, 16'h0104);  // LDA 104 (=0BAD)
    poke(12'h01B, 16'h401D);  // JMP 01D
    poke(12'h01C, 16'h0105);  // LDA 105 (=600D)
    poke(12'h01D, 16'h1201);  // STO 201
    poke(12'h01E, 16'h8123);  // reserved opcode
    poke(12'h01F, 16'hF000);  // reserved opcode
    poke(12'h020, 16'h0106);  // LDA 106 (=7FFF)
    poke(12'h021, 16'h2107);  // ADD 107 (=1) -> 8000
    poke(12'h022, 16'h1202);  // STO 202
    poke(12'h023, 16'h3100);  // SUB 100 -> 7FFB
    poke(12'h024, 16'h1203);  // STO 203
    poke(12'h025, 16'h0109);  // LDA 109 (=7ABC)
    poke(12'h026, 16'h5FFF);  // JPOS positive: taken to FFF
    poke(12'hFFF, 16'h1000);  // STO 000, then PC wraps to 0
    poke(12'h100, 16'h0005);
    poke(12'h101, 16'hFFFF);
    poke(12'h102, 16'h0007);
    poke(12'h103, 16'h0000);
    poke(12'h104, 16'h0BAD);
    poke(12'h105, 16'h600D);
    poke(12'h106, 16'h7FFF);
    poke(12'h107, 16'h0001);
    poke(12'h109, 16'h7ABC);

    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    running = 1'b1;
    @(negedge clk);
    // R1: reset state, first access is a read at address 0
    check(halt0 == 0 && halt1 == 0, "R1", int'(halt0), 0);
    check(re0 && addr0 == 12'h000, "R1", int'(addr0), 0);

    done = 0;
    for (int c = 0; c < 3000 && !done; c++) begin
      @(negedge clk);
      if (halt0 && halt1) done = 1;
    end
    if (!done) check(1'b0, "R8 watchdog", int'({halt1, halt0}), 3);
    repeat (6) @(negedge clk);  // halted must stay quiet (R8)

    check(mem0[12'h200] == 16'hFFFD, "R3", int'(mem0[12'h200]), 16'hFFFD);
    check(mem0[12'h202] == 16'h8000, "R3", int'(mem0[12'h202]), 16'h8000);
    check(mem0[12'h203] == 16'h7FFB, "R3", int'(mem0[12'h203]), 16'h7FFB);
    check(mem0[12'h201] == 16'h600D, "R6", int'(mem0[12'h201]), 16'h600D);
    check(mem1[12'h201] == 16'h0BAD, "R6", int'(mem1[12'h201]), 16'h0BAD);
    check(mem1[12'h203] == 16'h7FFB, "R3", int'(mem1[12'h203]), 16'h7FFB);
    check(mem0[12'h000] == 16'h7ABC, "R2", int'(mem0[12'h000]), 16'h7ABC);
    check(mem0[12'h1FF] == 16'h0000 && mem0[12'h123] == 16'h0000, "R9",
          int'(mem0[12'h123]), 0);
    check(halt0 && !re0 && !we0, "R8", int'({halt0, re0, we0}), 4);
    check(halt1 && !re1 && !we1, "R8", int'({halt1, re1, we1}), 4);
    check(mem0[12'h016] == 16'h7000, "R10", int'(mem0[12'h016]), 16'h7000);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule